// File: doc/BRIEF.md
# Byte-Exchange SPI Master with Register Interface

This block is a SPI master driven through four 32-bit registers on a simple synchronous read/write bus. It runs only in single-byte mode. Software polls a ready flag and then writes a byte to the transmit register. That write starts one full-duplex 8-bit exchange, most significant bit first. While the byte goes out on MOSI, eight bits are captured from MISO into the receive register. Software frames a transaction by setting and clearing per-device select enables, which drive active-low select pins.

The serial clock comes from a 5-bit divider code that covers two ranges: a direct range and a doubled range. All four polarity/phase combinations are supported. A self-clearing flush command empties the receive path. Register reads are combinational on the address. Writes take effect on the rising clock edge where `bus_wr` is high.

Top module: `spi_legacy_master`

## Requirements
- R1: After reset, the control register reads 0x00000002 (ready set, no selects), configuration and receive registers read 0, every `cs_n` line is high, and `sclk` and `mosi` are low.
- R2: Register word index is `bus_addr[3:2]`: 0 = control, 1 = configuration, 2 = transmit, 3 = receive. In configuration, only the divider code [4:0], phase [6], polarity [7] and flush [9] hold a value; every other bit, including bits 5 and 17, reads 0.
- R3: Control bit 16+n is a writable select enable; while it is 1, `cs_n[n]` is low. Control bit 1 is read-only.
- R4: A transmit write while control bit 1 (ready) is 1 starts an exchange of data bits [7:0]. Ready reads 0 from the cycle after the write. It returns to 1 on the same edge that produces the last SCLK edge, and the receive register (bits [7:0]) then holds the captured byte.
- R5: The period D in input clocks is the code for codes 2..15 and 2×(code−16) for codes 17..31; codes 0, 1 and 16 give D=2. The exchange makes 16 SCLK edges and takes 8×D cycles from the write edge until ready returns. Each period starts with an idle-level half of D−⌊D/2⌋ cycles.
- R6: Configuration bit 7 sets the SCLK idle level (0 = low, 1 = high); SCLK is at that level whenever ready is 1.
- R7: With phase bit 6 = 0, MOSI shows data bit 7 from the cycle after the write. MISO is sampled on each leading SCLK edge and MOSI changes on trailing edges.
- R8: With phase bit 6 = 1, MOSI keeps its previous value until the first leading edge. Each bit is launched on a leading edge and MISO is sampled on each trailing edge.
- R9: A transmit write while ready is 0 is ignored. It starts no SCLK edges, does not change the byte in flight, and does not affect the receive register or the completion time.
- R10: Writing 1 to configuration bit 9 sets it. It reads 1 for FLUSH_CYCLES cycles and then clears by itself, and at that moment the receive register becomes 0.
- R11: MOSI holds the last transmitted bit (data bit 0) between exchanges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| cs_n | output | NCS | Active-low device selects |

## Verification
The bench sweeps divider codes across both ranges, including the fold-to-two codes 0 and 16 and the odd code 3, so a wrong range formula or an off-by-one half period shows up as a wrong cycle count or edge count. Each polarity/phase mode exchanges distinct bytes with a bench device model. A design that samples on the wrong edge or launches MOSI early under phase 1 returns shifted or corrupted bytes, or shows a bit-7 MOSI level before the first edge. A transmit write is also issued mid-exchange: a design that accepts it restarts the clock, corrupts the byte or delays completion. The flush test checks both that the bit clears by itself and that the receive byte is wiped.

// File: rtl/spi_lm_pkg.sv
// Shared constants and helpers for the byte-exchange SPI master.
// Assumes 32-bit registers on word-aligned byte addresses.
package spi_lm_pkg;
    localparam int REG_W     = 32;
    localparam int BYTE_W    = 8;
    localparam int PRE_W     = 5;
    localparam int DIV_W     = 6;
    localparam int RDY_BIT   = 1;
    localparam int SEL_BASE  = 16;
    localparam int PHA_BIT   = 6;
    localparam int POL_BIT   = 7;
    localparam int FLUSH_BIT = 9;

    typedef enum logic [1:0] {
        IDX_CTRL = 2'd0,
        IDX_CFG  = 2'd1,
        IDX_TX   = 2'd2,
        IDX_RX   = 2'd3
    } reg_idx_t;

    // Map a divider code to a period in input clocks (never below 2).
    function automatic logic [DIV_W-1:0] code_to_div(input logic [PRE_W-1:0] code);
        logic [DIV_W-1:0] d;
        if (code[PRE_W-1]) d = {code[PRE_W-2:0], 1'b0};
        else               d = {2'b00, code[PRE_W-2:0]};
        if (d < DIV_W'(2)) d = DIV_W'(2);
        return d;
    endfunction
endpackage

// File: rtl/spi_lm_regs.sv
// Register file: control (selects, ready), configuration (divider,
// mode, flush), transmit launch and receive byte. Assumes ADDR_W >= 4.
module spi_lm_regs
    import spi_lm_pkg::*;
#(
    parameter int NCS          = 4,
    parameter int FLUSH_CYCLES = 4,
    parameter int ADDR_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              ready,
    input  logic              xfer_done,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              launch,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [NCS-1:0]    sel_en,
    output logic [PRE_W-1:0]  cfg_pre,
    output logic              cfg_pha,
    output logic              cfg_pol,
    output logic              flush_on,
    output logic [BYTE_W-1:0] din_q
);
    localparam int FCW = $clog2(FLUSH_CYCLES + 1);

    reg_idx_t       idx;
    logic           wr_ctrl, wr_cfg, wr_tx;
    logic           flush_start, flush_done;
    logic [FCW-1:0] fl_cnt;
    logic           unused_bits;

    assign idx         = reg_idx_t'(bus_addr[3:2]);
    assign wr_ctrl     = bus_wr && (idx == IDX_CTRL);
    assign wr_cfg      = bus_wr && (idx == IDX_CFG);
    assign wr_tx       = bus_wr && (idx == IDX_TX);
    assign launch      = wr_tx && ready;
    assign tx_byte     = bus_wdata[BYTE_W-1:0];
    assign flush_start = wr_cfg && bus_wdata[FLUSH_BIT] && !flush_on;
    assign flush_done  = flush_on && (fl_cnt == '0);
    assign unused_bits = ^{bus_addr, bus_wdata};

    // Select enables, written through the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       sel_en <= '0;
        else if (wr_ctrl) sel_en <= bus_wdata[SEL_BASE +: NCS];
    end

    // Divider code and clock mode fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_pre <= '0;
            cfg_pha <= 1'b0;
            cfg_pol <= 1'b0;
        end else if (wr_cfg) begin
            cfg_pre <= bus_wdata[PRE_W-1:0];
            cfg_pha <= bus_wdata[PHA_BIT];
            cfg_pol <= bus_wdata[POL_BIT];
        end
    end

    // Self-clearing flush command with a fixed duration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_on <= 1'b0;
            fl_cnt   <= '0;
        end else if (flush_start) begin
            flush_on <= 1'b1;
            fl_cnt   <= FCW'(FLUSH_CYCLES - 1);
        end else if (flush_done) begin
            flush_on <= 1'b0;
        end else if (flush_on) begin
            fl_cnt   <= fl_cnt - 1'b1;
        end
    end

    // Receive byte: cleared by flush, loaded on exchange completion.
    always_ff @(posedge clk) begin
        if (!rst_n)         din_q <= '0;
        else if (flush_done) din_q <= '0;
        else if (xfer_done)  din_q <= rx_byte;
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (idx)
            IDX_CTRL: begin
                bus_rdata[SEL_BASE +: NCS] = sel_en;
                bus_rdata[RDY_BIT]         = ready;
            end
            IDX_CFG: begin
                bus_rdata[PRE_W-1:0] = cfg_pre;
                bus_rdata[PHA_BIT]   = cfg_pha;
                bus_rdata[POL_BIT]   = cfg_pol;
                bus_rdata[FLUSH_BIT] = flush_on;
            end
            IDX_RX:  bus_rdata[BYTE_W-1:0] = din_q;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_lm_sclkgen.sv
// Serial clock generator: while run is high, makes SCLK periods of
// code_to_div(pre) cycles, idle-level half first, and flags each edge.
// Assumes run drops the cycle after the last trailing edge.
module spi_lm_sclkgen
    import spi_lm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] pre,
    input  logic             pol,
    output logic             lead,
    output logic             trail,
    output logic             sclk
);
    logic [DIV_W-1:0] div, half_idle, half_act, cnt;
    logic             lvl;

    assign div       = code_to_div(pre);
    assign half_act  = div >> 1;
    assign half_idle = div - half_act;
    assign lead      = run && !lvl && (cnt == half_idle - 1'b1);
    assign trail     = run &&  lvl && (cnt == half_act  - 1'b1);
    assign sclk      = lvl ^ pol;

    // Half-period counter and active-level flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            lvl <= 1'b0;
        end else if (lead) begin
            cnt <= '0;
            lvl <= 1'b1;
        end else if (trail) begin
            cnt <= '0;
            lvl <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_lm_shifter.sv
// Byte shift engine, MSB first. Phase 0: sample on leading, change on
// trailing. Phase 1: launch on leading, sample on trailing. Assumes
// launch only arrives while idle.
module spi_lm_shifter
    import spi_lm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              pha,
    input  logic              lead,
    input  logic              trail,
    input  logic              miso,
    output logic              busy,
    output logic              mosi,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int CW = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sh;
    logic [CW-1:0]     nbit;
    logic              last;

    assign last    = (nbit == CW'(BYTE_W - 1));
    assign done    = busy && trail && last;
    assign rx_byte = pha ? {sh[BYTE_W-2:0], miso} : sh;

    // Shift register, bit counter, busy flag and MOSI launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            sh   <= '0;
            nbit <= '0;
            mosi <= 1'b0;
        end else if (launch) begin
            busy <= 1'b1;
            sh   <= tx_byte;
            nbit <= '0;
            if (!pha) mosi <= tx_byte[BYTE_W-1];
        end else if (busy && lead) begin
            if (pha) mosi <= sh[BYTE_W-1];
            else     sh   <= {sh[BYTE_W-2:0], miso};
        end else if (busy && trail) begin
            if (pha)        sh   <= {sh[BYTE_W-2:0], miso};
            else if (!last) mosi <= sh[BYTE_W-1];
            nbit <= nbit + 1'b1;
            if (last) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_legacy_master.sv
// Top: register-driven SPI master exchanging one byte per transmit
// write. Assumes the bus never writes the configuration mid-exchange.
module spi_legacy_master
    import spi_lm_pkg::*;
#(
    parameter int NCS          = 4,
    parameter int FLUSH_CYCLES = 4,
    parameter int ADDR_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NCS-1:0]    cs_n
);
    logic              rdy, busy, launch, done, lead, trail;
    logic              cfg_pha, cfg_pol, flush_on;
    logic [PRE_W-1:0]  cfg_pre;
    logic [NCS-1:0]    sel_en;
    logic [BYTE_W-1:0] tx_byte, rx_byte, din_q;

    assign rdy  = !busy;
    assign cs_n = ~sel_en;

    spi_lm_regs #(
        .NCS(NCS), .FLUSH_CYCLES(FLUSH_CYCLES), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ready(rdy),
        .xfer_done(done), .rx_byte(rx_byte), .launch(launch),
        .tx_byte(tx_byte), .sel_en(sel_en), .cfg_pre(cfg_pre),
        .cfg_pha(cfg_pha), .cfg_pol(cfg_pol), .flush_on(flush_on),
        .din_q(din_q)
    );

    spi_lm_sclkgen u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(busy), .pre(cfg_pre),
        .pol(cfg_pol), .lead(lead), .trail(trail), .sclk(sclk)
    );

    spi_lm_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .launch(launch), .tx_byte(tx_byte),
        .pha(cfg_pha), .lead(lead), .trail(trail), .miso(miso),
        .busy(busy), .mosi(mosi), .done(done), .rx_byte(rx_byte)
    );
endmodule

// File: rtl/spi_lm_chk.sv
// Property checker for spi_legacy_master, attached by bind.
module spi_lm_chk #(
    parameter int NCS    = 4,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              sclk,
    input logic              mosi,
    input logic [NCS-1:0]    cs_n,
    input logic              ready,
    input logic              cpol,
    input logic [7:0]        din,
    input logic              flush_on
);
    logic wr_tx, wr_ctrl;
    assign wr_tx   = bus_wr && (bus_addr[3:2] == 2'd2);
    assign wr_ctrl = bus_wr && (bus_addr[3:2] == 2'd0);

    // R4
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && ready) |=> !ready);
    // R6
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (sclk == cpol));
    // R11
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !wr_tx) |=> $stable(mosi));
    // R3
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(cs_n));
    // R9
    rx_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(din) && (din != 8'h00)) |-> $rose(ready));
    // R10
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush_on) |-> (din == 8'h00));
endmodule

bind spi_legacy_master spi_lm_chk #(.NCS(NCS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .ready(rdy), .cpol(cfg_pol),
    .din(din_q), .flush_on(flush_on)
);

// File: tb/spi_legacy_master_tb.sv
module spi_legacy_master_tb;
    localparam int NCS = 4;
    localparam int FLC = 4;
    localparam logic [3:0] A_CTRL = 4'h0, A_CFG = 4'h4, A_TX = 4'h8, A_RX = 4'hC;

    logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, miso = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        sclk, mosi;
    logic [NCS-1:0] cs_n;

    int n_chk = 0, n_bad = 0;
    logic [7:0] s_byte = '0, s_rx = '0;
    int  s_idx = 0, s_edges = 0;
    bit  slave_on = 1'b0, s_cpol = 1'b0, s_cpha = 1'b0;
    logic idle_mosi = 1'b0;

    spi_legacy_master #(.NCS(NCS), .FLUSH_CYCLES(FLC), .ADDR_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk),
        .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #10 clk = ~clk;

    // Device model: counts edges, samples and drives per the bench mode.
    always @(sclk) begin
        if (slave_on) begin
            s_edges++;
            if (sclk != s_cpol) begin
                if (!s_cpha) s_rx = {s_rx[6:0], mosi};
                else if (s_idx >= 0) begin miso = s_byte[s_idx]; s_idx--; end
            end else begin
                if (s_cpha) s_rx = {s_rx[6:0], mosi};
                else if (s_idx >= 0) begin miso = s_byte[s_idx]; s_idx--; end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_div(input int code);
        int d;
        d = (code < 16) ? code : 2 * (code - 16);
        return (d < 2) ? 2 : d;
    endfunction

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic test_reset();
        logic [31:0] rd;
        reg_read(A_CTRL, rd); chk(rd == 32'h2, "R1 ctrl", rd, 32'h2);
        reg_read(A_CFG, rd);  chk(rd == 0, "R1 cfg", rd, 0);
        reg_read(A_RX, rd);   chk(rd == 0, "R1 rx", rd, 0);
        chk(cs_n == 4'hF, "R1 cs_n", 32'(cs_n), 32'hF);
        chk(sclk == 0 && mosi == 0, "R1 sclk/mosi", {30'd0, sclk, mosi}, 0);
    endtask

    task automatic test_regs();
        logic [31:0] rd;
        reg_write(A_CFG, 32'hFFFF_FDFF);
        reg_read(A_CFG, rd); chk(rd == 32'hDF, "R2 cfg reserved bits", rd, 32'hDF);
        reg_write(A_CFG, 32'h0);
        reg_write(A_CTRL, 32'hFFFF_FFFF);
        chk(cs_n == 4'h0, "R3 all selects", 32'(cs_n), 0);
        reg_read(A_CTRL, rd); chk(rd == 32'h000F_0002, "R3 ctrl readback", rd, 32'h000F_0002);
        reg_write(A_CTRL, 32'h0005_0000);
        chk(cs_n == 4'b1010, "R3 select pattern", 32'(cs_n), 32'hA);
        chk(mosi == 0 && sclk == 0, "R11 idle lines", {30'd0, sclk, mosi}, 0);
    endtask

    task automatic run_xfer(input logic [1:0] mode, input int code,
                            input logic [7:0] tx, input logic [7:0] sb, input bit extra);
        logic [31:0] rd;
        int d, n;
        d = exp_div(code);
        reg_write(A_CFG, {24'd0, mode[1], mode[0], 1'b0, 5'(code)});
        s_cpol = mode[1]; s_cpha = mode[0]; s_byte = sb; s_rx = '0; s_edges = 0;
        if (!mode[0]) begin miso = sb[7]; s_idx = 6; end
        else s_idx = 7;
        slave_on = 1'b1;
        reg_write(A_TX, {24'd0, tx});
        reg_read(A_CTRL, rd); chk(rd[1] == 1'b0, "R4 ready low after launch", rd, 0);
        if (mode[0]) chk(mosi == idle_mosi, "R8 no early launch", 32'(mosi), 32'(idle_mosi));
        else         chk(mosi == tx[7], "R7 bit7 before first edge", 32'(mosi), 32'(tx[7]));
        n = 0;
        while (n < 2000) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (extra && n == 3) bus_wr = 1'b0;
            reg_read(A_CTRL, rd);
            if (rd[1]) break;
            if (extra && n == 2) begin bus_wr = 1'b1; bus_addr = A_TX; bus_wdata = 32'hFF; end
        end
        chk(n == 8 * d, "R5 exchange cycles", n, 8 * d);
        reg_read(A_RX, rd); chk(rd == {24'd0, sb}, "R4 received byte", rd, {24'd0, sb});
        chk(s_rx == tx, mode[0] ? "R8 device captured" : "R7 device captured", s_rx, tx);
        chk(s_edges == 16, "R5 edge count", s_edges, 16);
        chk(sclk == mode[1], "R6 idle level", 32'(sclk), 32'(mode[1]));
        if (extra) begin
            repeat (20) @(negedge clk);
            reg_read(A_CTRL, rd); chk(rd[1] == 1'b1, "R9 no relaunch", rd, 2);
            chk(s_edges == 16, "R9 no extra edges", s_edges, 16);
        end
        slave_on = 1'b0;
        idle_mosi = tx[0];
        chk(mosi == idle_mosi, "R11 mosi holds", 32'(mosi), 32'(idle_mosi));
    endtask

    task automatic test_flush();
        logic [31:0] rd;
        int n;
        reg_write(A_CFG, 32'h0000_0203);
        reg_read(A_CFG, rd); chk(rd[9] == 1'b1, "R10 flush set", rd, 32'h203);
        n = 0;
        while (rd[9] && n < 100) begin
            @(posedge clk); n++;
            @(negedge clk);
            reg_read(A_CFG, rd);
        end
        chk(n == FLC, "R10 flush duration", n, FLC);
        reg_read(A_RX, rd); chk(rd == 0, "R10 rx cleared", rd, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        test_reset();
        test_regs();
        run_xfer(2'd0, 0,  8'hA5, 8'h3C, 1'b0);
        run_xfer(2'd1, 3,  8'h81, 8'h7E, 1'b0);
        run_xfer(2'd2, 16, 8'h5A, 8'hC3, 1'b0);
        run_xfer(2'd3, 20, 8'hF0, 8'h0F, 1'b0);
        run_xfer(2'd0, 15, 8'h12, 8'h34, 1'b0);
        run_xfer(2'd3, 17, 8'h00, 8'hFF, 1'b0);
        run_xfer(2'd1, 31, 8'h96, 8'h69, 1'b0);
        run_xfer(2'd0, 4,  8'hC6, 8'h9B, 1'b1);
        test_flush();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule